// File: doc/BRIEF.md
# Virtual interrupt maintenance controller

This block keeps the hypervisor's control word for one virtual interrupt interface and turns a set of live status inputs into a single level-sensitive maintenance interrupt. Software reads and writes the control word through a simple single-cycle port. The word holds a global enable, seven condition enables and a five-bit count of end-of-interrupt (EOI) requests that found no matching list entry.

Each cycle, the block evaluates seven conditions from the inputs and from the register. The inputs are the list-entry valid and pending vectors, the guest's two group enables and the EOI count. Each condition is qualified by its own enable bit and reported on a status vector. The maintenance output is the OR of that vector, gated by the global enable. The same global enable also gates the virtual interrupt path: while it is clear, the guest sees no virtual interrupt and an acknowledge returns the spurious ID.

Top module: `vint_maint_ctrl`

## Requirements
- R1: After reset, every register field is 0, so a read returns 0x00000000 and the maintenance output is low.
- R2: Reads return the EOI count in bits [31:27], the control bits in [7:0] and zero in the reserved bits [26:8]. The control bits are: bit 0 global enable, bit 1 underflow enable, bit 2 entry-not-present enable, bit 3 no-pending enable, bit 4 group 0 enabled-enable, bit 5 group 0 disabled-enable, bit 6 group 1 enabled-enable, bit 7 group 1 disabled-enable.
- R3: The count rises by one on a cycle with `eoi_valid`, `eoi_no_entry` and `eoi_prio_cleared` all high; any other EOI cycle leaves it unchanged.
- R4: An increment from 31 wraps the count to 0.
- R5: A write loads the count from bits [31:27]; a write in the same cycle as an increment wins.
- R6: Status bit 1 (entry-not-present) is high when control bit 2 is set and the count is nonzero.
- R7: Status bit 0 (underflow) is high when control bit 1 is set and at most one list entry is valid.
- R8: Status bit 2 (no-pending) is high when control bit 3 is set and no list entry is pending.
- R9: Status bits 3, 4, 5 and 6 are high when their enable is set and the guest group state matches. Bit 3 needs control bit 4 with group 0 enabled, bit 4 needs control bit 5 with group 0 disabled, bit 5 needs control bit 6 with group 1 enabled, and bit 6 needs control bit 7 with group 1 disabled. Status does not depend on the global enable.
- R10: `maint_irq` is high in the same cycle exactly when the global enable is set and any status bit is high.
- R11: When the global enable is 0, `virq_gate` is 0 and `ack_id_out` is 1023. When it is 1, `virq_gate` is 1 and `ack_id_out` equals `ack_id_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| entry_valid | input | 4 | Per-list-entry valid flags |
| entry_pending | input | 4 | Per-list-entry pending flags |
| guest_grp0_en | input | 1 | Guest group 0 signalling enable |
| guest_grp1_en | input | 1 | Guest group 1 signalling enable |
| eoi_valid | input | 1 | EOI event strobe |
| eoi_no_entry | input | 1 | EOI had no matching list entry |
| eoi_prio_cleared | input | 1 | EOI cleared an active-priority bit |
| ack_id_in | input | 10 | Interrupt ID proposed for acknowledge |
| ack_id_out | output | 10 | Interrupt ID returned to the guest |
| virq_gate | output | 1 | Virtual interrupt signalling allowed |
| maint_irq | output | 1 | Level maintenance interrupt |
| cond_status | output | 7 | Per-condition qualified status |

## Verification
The embedded assertions watch the counter on every cycle: a step of exactly one on a qualified EOI, a hold otherwise, the wrap at 31, and a write taking priority over an increment. They also tie the underflow flag to the number of valid entries and keep the maintenance and acknowledge outputs quiet while the global enable is clear. Whether each status bit pairs with the intended control bit and group polarity, and whether reserved bits really read back as zero, shows only in the bench. The bench compares every output against a behavioural model over random register contents and input mixes. Directed sequences cover the wrap and the write-versus-EOI collision.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
   // control bit positions inside the register
   localparam int CTL_W          = 8;
   localparam int CB_GLOBAL      = 0;
   localparam int CB_UNDERFLOW   = 1;
   localparam int CB_NOENTRY     = 2;
   localparam int CB_NOPEND      = 3;
   localparam int CB_G0_ON       = 4;
   localparam int CB_G0_OFF      = 5;
   localparam int CB_G1_ON       = 6;
   localparam int CB_G1_OFF      = 7;

   // status vector positions
   localparam int NUM_COND       = 7;
   localparam int SB_UNDERFLOW   = 0;
   localparam int SB_NOENTRY     = 1;
   localparam int SB_NOPEND      = 2;
   localparam int SB_G0_ON       = 3;
   localparam int SB_G0_OFF      = 4;
   localparam int SB_G1_ON       = 5;
   localparam int SB_G1_OFF      = 6;

   typedef struct packed {
      logic g1_off;
      logic g1_on;
      logic g0_off;
      logic g0_on;
      logic nopend;
      logic noentry;
      logic underflow;
      logic global_en;
   } ctl_t;
endpackage

// File: rtl/vmc_ctrl_reg.sv
module vmc_ctrl_reg
   import vmc_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             eoi_valid,
   input  logic             eoi_no_entry,
   input  logic             eoi_prio_cleared,
   output logic [REG_W-1:0] rdata,
   output ctl_t             ctl,
   output logic [CNT_W-1:0] cnt
);
   localparam int CNT_LSB = REG_W - CNT_W;
   localparam int RSV_W   = REG_W - CNT_W - CTL_W;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (RSV_W < 0) begin : g_bad_width
         initial $error("vmc_ctrl_reg: REG_W too small for count and control");
      end
   endgenerate

   logic             bump;
   ctl_t             ctl_q;
   logic [CNT_W-1:0] cnt_q;

   assign bump = eoi_valid & eoi_no_entry & eoi_prio_cleared;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cnt_q <= '0;
      end else if (wr) begin
         ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
         cnt_q <= wdata[REG_W-1:CNT_LSB];
      end else if (bump) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (RSV_W > 0) begin : g_rsv
         assign rdata = {cnt_q, {RSV_W{1'b0}}, ctl_q};
      end else begin : g_norsv
         assign rdata = {cnt_q, ctl_q};
      end
   endgenerate

   assign ctl = ctl_q;
   assign cnt = cnt_q;

   // R3: one step on a qualified EOI
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !wr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
   // R3: other cycles without write keep the count
   a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bump && !wr) |=> $stable(cnt_q));
   // R4: wrap at maximum
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !wr && cnt_q == CNT_MAX) |=> cnt_q == '0);
   // R5: write wins over increment
   a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> cnt_q == $past(wdata[REG_W-1:CNT_LSB]));
endmodule

// File: rtl/vmc_cond.sv
module vmc_cond
   import vmc_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int CNT_W       = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  ctl_t                   ctl,
   input  logic [CNT_W-1:0]       cnt,
   input  logic [NUM_ENTRIES-1:0] entry_valid,
   input  logic [NUM_ENTRIES-1:0] entry_pending,
   input  logic                   guest_grp0_en,
   input  logic                   guest_grp1_en,
   output logic [NUM_COND-1:0]    status
);
   generate
      if (NUM_ENTRIES < 1) begin : g_bad_entries
         initial $error("vmc_cond: NUM_ENTRIES must be at least 1");
      end
   endgenerate

   // at-most-one detector: ripple of "seen one" and "seen two"
   logic [NUM_ENTRIES:0] seen1;
   logic [NUM_ENTRIES:0] seen2;
   logic                 at_most_one;
   logic                 none_pending;

   assign seen1[0] = 1'b0;
   assign seen2[0] = 1'b0;
   generate
      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_scan
         assign seen1[i+1] = seen1[i] | entry_valid[i];
         assign seen2[i+1] = seen2[i] | (seen1[i] & entry_valid[i]);
      end
   endgenerate
   assign at_most_one  = ~seen2[NUM_ENTRIES];
   assign none_pending = ~(|entry_pending);

   always_comb begin
      status               = '0;
      status[SB_UNDERFLOW] = ctl.underflow & at_most_one;
      status[SB_NOENTRY]   = ctl.noentry & (|cnt);
      status[SB_NOPEND]    = ctl.nopend & none_pending;
      status[SB_G0_ON]     = ctl.g0_on  &  guest_grp0_en;
      status[SB_G0_OFF]    = ctl.g0_off & ~guest_grp0_en;
      status[SB_G1_ON]     = ctl.g1_on  &  guest_grp1_en;
      status[SB_G1_OFF]    = ctl.g1_off & ~guest_grp1_en;
   end

   // R7: underflow flag only with zero or one valid entry
   a_r7_underflow_count: assert property (@(posedge clk) disable iff (!rst_n)
      status[SB_UNDERFLOW] |-> $countones(entry_valid) <= 1);
   // R7: two valid entries never flag underflow
   a_r7_underflow_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(entry_valid) > 1) |-> !status[SB_UNDERFLOW]);
   // R9: a group cannot be flagged both enabled and disabled
   a_r9_g0_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[SB_G0_ON] && status[SB_G0_OFF]));
endmodule

// File: rtl/vmc_gate.sv
module vmc_gate
   import vmc_pkg::*;
#(
   parameter int ID_W     = 10,
   parameter int SPUR_ID  = 1023
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                global_en,
   input  logic [NUM_COND-1:0] status,
   input  logic [ID_W-1:0]     ack_id_in,
   output logic [ID_W-1:0]     ack_id_out,
   output logic                virq_gate,
   output logic                maint_irq
);
   localparam logic [ID_W-1:0] SPUR = ID_W'(SPUR_ID);

   generate
      if (SPUR_ID >= (1 << ID_W)) begin : g_bad_spur
         initial $error("vmc_gate: SPUR_ID does not fit in ID_W");
      end
   endgenerate

   assign maint_irq  = global_en & (|status);
   assign virq_gate  = global_en;
   assign ack_id_out = global_en ? ack_id_in : SPUR;

   // R10: disabled interface never raises maintenance
   a_r10_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      !virq_gate |-> !maint_irq);
   // R10: any qualified condition while enabled raises it
   a_r10_any_cond: assert property (@(posedge clk) disable iff (!rst_n)
      (virq_gate && status != '0) |-> maint_irq);
   // R11: disabled acknowledge is spurious
   a_r11_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !virq_gate |-> ack_id_out == SPUR);
endmodule

// File: rtl/vint_maint_ctrl.sv
module vint_maint_ctrl
   import vmc_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int CNT_W       = 5,
   parameter int NUM_ENTRIES = 4,
   parameter int ID_W        = 10,
   parameter int SPUR_ID     = 1023
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [REG_W-1:0]       reg_wdata,
   output logic [REG_W-1:0]       reg_rdata,
   input  logic [NUM_ENTRIES-1:0] entry_valid,
   input  logic [NUM_ENTRIES-1:0] entry_pending,
   input  logic                   guest_grp0_en,
   input  logic                   guest_grp1_en,
   input  logic                   eoi_valid,
   input  logic                   eoi_no_entry,
   input  logic                   eoi_prio_cleared,
   input  logic [ID_W-1:0]        ack_id_in,
   output logic [ID_W-1:0]        ack_id_out,
   output logic                   virq_gate,
   output logic                   maint_irq,
   output logic [NUM_COND-1:0]    cond_status
);
   ctl_t             ctl;
   logic [CNT_W-1:0] cnt;

   vmc_ctrl_reg #(.REG_W(REG_W), .CNT_W(CNT_W)) u_reg (
      .clk              (clk),
      .rst_n            (rst_n),
      .wr               (reg_wr),
      .wdata            (reg_wdata),
      .eoi_valid        (eoi_valid),
      .eoi_no_entry     (eoi_no_entry),
      .eoi_prio_cleared (eoi_prio_cleared),
      .rdata            (reg_rdata),
      .ctl              (ctl),
      .cnt              (cnt)
   );

   vmc_cond #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_cond (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl           (ctl),
      .cnt           (cnt),
      .entry_valid   (entry_valid),
      .entry_pending (entry_pending),
      .guest_grp0_en (guest_grp0_en),
      .guest_grp1_en (guest_grp1_en),
      .status        (cond_status)
   );

   vmc_gate #(.ID_W(ID_W), .SPUR_ID(SPUR_ID)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .global_en  (ctl.global_en),
      .status     (cond_status),
      .ack_id_in  (ack_id_in),
      .ack_id_out (ack_id_out),
      .virq_gate  (virq_gate),
      .maint_irq  (maint_irq)
   );

   // R1: register reads zero in the cycle after reset
   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> reg_rdata == '0);
endmodule

// File: tb/test_vint_maint_ctrl.sv
module test_vint_maint_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] entry_valid = '0;
   logic [N-1:0] entry_pending = '0;
   logic        guest_grp0_en = 1'b0;
   logic        guest_grp1_en = 1'b0;
   logic        eoi_valid = 1'b0;
   logic        eoi_no_entry = 1'b0;
   logic        eoi_prio_cleared = 1'b0;
   logic [9:0]  ack_id_in = '0;
   logic [9:0]  ack_id_out;
   logic        virq_gate;
   logic        maint_irq;
   logic [6:0]  cond_status;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural model state
   int         m_cnt = 0;
   logic [7:0] m_ctl = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vint_maint_ctrl i_vint_maint_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .entry_valid(entry_valid),
      .entry_pending(entry_pending), .guest_grp0_en(guest_grp0_en),
      .guest_grp1_en(guest_grp1_en), .eoi_valid(eoi_valid),
      .eoi_no_entry(eoi_no_entry), .eoi_prio_cleared(eoi_prio_cleared),
      .ack_id_in(ack_id_in), .ack_id_out(ack_id_out), .virq_gate(virq_gate),
      .maint_irq(maint_irq), .cond_status(cond_status)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every output against the model with current inputs
   task automatic compare_all();
      int  nvalid;
      bit  st[7];
      bit  anyst;
      bit  en;
      nvalid = $countones(entry_valid);
      en = m_ctl[0];
      st[0] = m_ctl[1] && (nvalid <= 1);
      st[1] = m_ctl[2] && (m_cnt != 0);
      st[2] = m_ctl[3] && (entry_pending == 0);
      st[3] = m_ctl[4] &&  guest_grp0_en;
      st[4] = m_ctl[5] && !guest_grp0_en;
      st[5] = m_ctl[6] &&  guest_grp1_en;
      st[6] = m_ctl[7] && !guest_grp1_en;
      anyst = 0;
      foreach (st[k]) anyst |= st[k];
      chk("R2 readback", reg_rdata, {m_cnt[4:0], 19'b0, m_ctl});
      chk("R7 underflow", cond_status[0], st[0]);
      chk("R6 entry-not-present", cond_status[1], st[1]);
      chk("R8 no-pending", cond_status[2], st[2]);
      chk("R9 group status", cond_status[6:3], {st[6], st[5], st[4], st[3]});
      chk("R10 maint", maint_irq, en && anyst);
      chk("R11 gate", virq_gate, en);
      chk("R11 ack id", ack_id_out, en ? longint'(ack_id_in) : 1023);
   endtask

   // one cycle: drive at negedge, check, then the posedge applies it
   task automatic step(input bit wr, input logic [31:0] wd, input logic [N-1:0] v,
                       input logic [N-1:0] p, input bit g0, input bit g1,
                       input bit eo, input bit ne, input bit pc, input logic [9:0] id);
      @(negedge clk);
      reg_wr = wr; reg_wdata = wd; entry_valid = v; entry_pending = p;
      guest_grp0_en = g0; guest_grp1_en = g1; eoi_valid = eo;
      eoi_no_entry = ne; eoi_prio_cleared = pc; ack_id_in = id;
      #1;
      compare_all();
      if (wr) begin
         m_cnt = int'(wd[31:27]);
         m_ctl = wd[7:0];
      end else if (eo && ne && pc) begin
         m_cnt = (m_cnt + 1) % 32;
      end
   endtask

   task automatic idle();
      step(0, '0, 4'b0011, 4'b0001, 0, 0, 0, 0, 0, 10'd5);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 reset read", reg_rdata, 0);
      chk("R1 reset maint", maint_irq, 0);
      chk("R1 reset status", cond_status, 0);
      rst_n = 1'b1;

      // R2: reserved bits read zero
      step(1, 32'hFFFF_FFFF, '0, '0, 0, 0, 0, 0, 0, 10'd7);
      idle();
      // R3: partial qualifiers do not count
      step(1, 32'h0000_0005, '0, '0, 0, 0, 0, 0, 0, 10'd7);
      step(0, '0, '0, '0, 0, 0, 1, 1, 0, 10'd7);
      step(0, '0, '0, '0, 0, 0, 1, 0, 1, 10'd7);
      step(0, '0, '0, '0, 0, 0, 0, 1, 1, 10'd7);
      step(0, '0, '0, '0, 0, 0, 1, 1, 1, 10'd7);
      idle();
      chk("R3 count one", reg_rdata[31:27], 1);
      // R4: wrap from 31
      step(1, {5'd30, 19'b0, 8'h05}, '0, '0, 0, 0, 0, 0, 0, 10'd1);
      step(0, '0, '0, '0, 0, 0, 1, 1, 1, 10'd1);
      step(0, '0, '0, '0, 0, 0, 1, 1, 1, 10'd1);
      idle();
      chk("R4 wrap", reg_rdata[31:27], 0);
      chk("R6 zero count clears", cond_status[1], 0);
      // R5: write and increment together
      step(1, {5'd9, 19'b0, 8'h05}, '0, '0, 0, 0, 1, 1, 1, 10'd1);
      idle();
      chk("R5 write wins", reg_rdata[31:27], 9);

      // random mixes
      for (int i = 0; i < 400; i++) begin
         logic [31:0] wd;
         wd = $urandom;
         step(($urandom % 6) == 0, wd, N'($urandom), N'($urandom % 3 == 0 ? 0 : $urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              10'($urandom));
      end
      idle();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule